// File: doc/BRIEF.md
# Serial Sample Output Port

This block is the device side of a chip-select framed serial link that hands out one sample per frame. A host lowers the active-low select line, and the block captures the parallel sample presented on its input at that moment. It then shifts out a fixed sixteen-bit frame, one bit per falling edge of the host's serial clock. The block can stand in for a converter peripheral when a host controller is being tested. The data pin is modelled as a data bit plus a separate drive-enable, so the block itself contains no tristate nets. The enable is low (line released) whenever no frame is in progress.

Select and serial clock are brought into a fast system clock through two-flop synchronisers, and edge detectors turn them into single-cycle events. A three-state controller acts on these events. IDLE waits for the select to fall and moves to SHIFT on that event (transition LOAD). SHIFT returns to IDLE when the select rises (transition ABORT), and moves to DONE on the sixteenth serial clock fall (transition FINISH). DONE ignores the serial clock and returns to IDLE when the select rises (transition RELEASE). A mode input picks a twelve-bit payload (four zeros, then twelve data bits) or a ten-bit payload (four zeros, ten data bits, then two zeros). The data bits are passed unchanged as twos-complement values, most significant bit first.

Timing is counted from an input change that is set up before a system clock edge. Events derived from that change take effect on the third rising edge of the system clock after it.

Top module: `serial_sample_port`

## Requirements
- R1: While the select is high, the enable is low. After the select falls, the enable goes high on the third rising system clock edge.
- R2: The sample and the mode input are captured when the select falls. Changes to either during the frame do not alter the bits sent.
- R3: After the first bit, the data output changes only following a detected falling edge of the serial clock, one frame bit per edge, MSB first.
- R4: With the mode input at 0, the frame is four 0 bits followed by sample bits 11 down to 0, sent unchanged as twos complement. Frame bit 15 (a zero) is presented as soon as the enable rises.
- R5: With the mode input at 1, the frame is four 0 bits, then sample bits 9 down to 0, then two 0 bits. Sample bits 11 and 10 are not sent.
- R6: The sixteenth falling serial clock edge of a frame drops the enable.
- R7: A rising select during a frame drops the enable at once and returns to IDLE. This holds even when a serial clock fall is detected in the same cycle; the rising select takes precedence.
- R8: Serial clock edges after the sixteenth leave the enable low and the data output at 0 until the select has risen and fallen again.
- R9: After reset, the enable is low, the data output is 0 and the controller is in IDLE.
- R10: The data output is 0 whenever the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial clock from the host, idle high |
| sample_in | input | SAMPLE_W (12) | Parallel twos-complement sample |
| narrow_mode | input | 1 | 0: twelve-bit payload, 1: ten-bit payload with two trailing zeros |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the serial data pin |

## Verification
The select rising and a serial clock fall can be decoded in the same system clock cycle. That cycle must end the frame and release the line, not shift another bit. The bench provokes this by changing both inputs on the same system clock edge in the middle of a frame. Because both signals pass through synchronisers of equal depth, the two events reach the controller together. The case is judged by checking that the enable is low, the data bit is 0, and a later frame still starts cleanly with all sixteen bits correct.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } sps_state_t;
endpackage

// File: rtl/sps_edge_sync.sv
module sps_edge_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {(STAGES+1){RESET_VAL}};
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level = pipe[STAGES-1];
    assign fall  =  pipe[STAGES] & ~pipe[STAGES-1];
    assign rise  = ~pipe[STAGES] &  pipe[STAGES-1];
endmodule

// File: rtl/sps_frame_builder.sv
module sps_frame_builder #(
    parameter int SAMPLE_W   = 12,
    parameter int NARROW_W   = 10,
    parameter int LEAD_ZEROS = 4,
    localparam int FRAME_W   = LEAD_ZEROS + SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                narrow,
    output logic [FRAME_W-1:0]  frame
);
    localparam int TRAIL = SAMPLE_W - NARROW_W;

    logic [FRAME_W-1:0] wide_frame;
    logic [FRAME_W-1:0] slim_frame;

    assign wide_frame = {{LEAD_ZEROS{1'b0}}, sample};

    generate
        if (TRAIL > 0) begin : g_pad
            assign slim_frame = {{LEAD_ZEROS{1'b0}}, sample[NARROW_W-1:0], {TRAIL{1'b0}}};
        end else begin : g_nopad
            assign slim_frame = wide_frame;
        end
    endgenerate

    assign frame = narrow ? slim_frame : wide_frame;
endmodule

// File: rtl/serial_sample_port.sv
module serial_sample_port
    import sps_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int NARROW_W    = 10,
    parameter int LEAD_ZEROS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                ser_clk,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                narrow_mode,
    output logic                sdata_o,
    output logic                sdata_oe
);
    localparam int FRAME_W = LEAD_ZEROS + SAMPLE_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    sps_state_t state, state_nx;

    logic               sel_level, cs_fall, cs_rise;
    logic               sclk_level, sclk_fall, sclk_rise;
    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               last_bit;

    sps_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .din(sel_n),
        .level(sel_level), .fall(cs_fall), .rise(cs_rise)
    );

    sps_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_clk),
        .level(sclk_level), .fall(sclk_fall), .rise(sclk_rise)
    );

    sps_frame_builder #(
        .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .LEAD_ZEROS(LEAD_ZEROS)
    ) u_frame (
        .sample(sample_in), .narrow(narrow_mode), .frame(frame_word)
    );

    assign last_bit = (bit_cnt == LAST_IDX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: LOAD, ABORT, FINISH, RELEASE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise)                    state_nx = ST_IDLE;
                else if (sclk_fall && last_bit) state_nx = ST_DONE;
            end
            ST_DONE:  if (cs_rise) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            sdata_o  <= 1'b0;
            sdata_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        shreg    <= frame_word;
                        bit_cnt  <= '0;
                        sdata_o  <= frame_word[FRAME_W-1];
                        sdata_oe <= 1'b1;
                    end else begin
                        sdata_o  <= 1'b0;
                        sdata_oe <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        sdata_o  <= 1'b0;
                        sdata_oe <= 1'b0;
                    end else if (sclk_fall) begin
                        if (last_bit) begin
                            sdata_o  <= 1'b0;
                            sdata_oe <= 1'b0;
                        end else begin
                            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                            sdata_o <= shreg[FRAME_W-2];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    sdata_o  <= 1'b0;
                    sdata_oe <= 1'b0;
                end
                default: begin
                    sdata_o  <= 1'b0;
                    sdata_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n,
    input logic       sdata_o,
    input logic       sdata_oe,
    input logic       cs_fall,
    input logic       cs_rise,
    input logic       sclk_fall,
    input sps_state_t state
);
    AST_SELECT_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && $past(sel_n) && $past(sel_n, 2)) |=> !sdata_oe); // R1

    AST_ENABLE_ONLY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(cs_fall)); // R1

    AST_FIRST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> !sdata_o); // R4

    AST_SHIFT_ON_SCLK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$past(sclk_fall)) |-> $stable(sdata_o)); // R3

    AST_FINISH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SHIFT && state == ST_DONE) |-> !sdata_oe); // R6

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdata_oe); // R7

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !sdata_oe); // R8

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata_o); // R10
endmodule

bind serial_sample_port sps_checker u_sps_checker (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
    .state(state)
);

// File: tb/tb_serial_sample_port.sv
module tb_serial_sample_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic [11:0] sample_in = '0;
    logic        narrow_mode = 1'b0;
    logic        sdata_o, sdata_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    serial_sample_port dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .sample_in(sample_in), .narrow_mode(narrow_mode),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_frame(input logic [11:0] v, input logic narrow);
        if (narrow) return {4'b0000, v[9:0], 2'b00};
        return {4'b0000, v};
    endfunction

    task automatic check_idle(input string req);
        chk({req, " enable"}, 32'(sdata_oe), 32'd0);
        chk({req, " data"},   32'(sdata_o),  32'd0);
    endtask

    // Full frame: R1 R2 R3 R4/R5 R6 R8
    task automatic run_frame(input logic [11:0] v, input logic narrow, input int extra);
        logic [15:0] fr;
        fr = exp_frame(v, narrow);
        sample_in   = v;
        narrow_mode = narrow;
        sel_n       = 1'b0;
        step();
        chk("R1 enable after select fall", 32'(sdata_oe), 32'd1);
        chk(narrow ? "R5 bit15" : "R4 bit15", 32'(sdata_o), 32'(fr[15]));
        sample_in   = ~v;       // R2: late change must not matter
        narrow_mode = ~narrow;
        for (int n = 1; n <= 16; n++) begin
            ser_clk = 1'b0;
            step();
            if (n < 16) begin
                chk("R3 enable held", 32'(sdata_oe), 32'd1);
                chk(narrow ? "R5 R2 frame bit" : "R4 R2 frame bit", 32'(sdata_o), 32'(fr[15-n]));
            end else begin
                check_idle("R6 after sixteenth fall");
            end
            ser_clk = 1'b1;
            step();
            if (n < 16) chk("R3 stable on sclk rise", 32'(sdata_o), 32'(fr[15-n]));
        end
        for (int e = 0; e < extra; e++) begin
            ser_clk = 1'b0; step();
            check_idle("R8 extra edge");
            ser_clk = 1'b1; step();
            check_idle("R8 extra edge");
        end
        sel_n = 1'b1;
        step();
        check_idle("R1 select high");
    endtask

    // Abort with optional coincident sclk fall: R7
    task automatic run_abort(input int edges, input logic coincide);
        sample_in   = 12'hFFF;
        narrow_mode = 1'b0;
        sel_n       = 1'b0;
        step();
        for (int n = 0; n < edges; n++) begin
            ser_clk = 1'b0; step();
            ser_clk = 1'b1; step();
        end
        sel_n = 1'b1;
        if (coincide) ser_clk = 1'b0;
        step();
        check_idle("R7 abort");
        ser_clk = 1'b1; step();
        ser_clk = 1'b0; step();
        check_idle("R7 sclk after abort");
        ser_clk = 1'b1; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset enable", 32'(sdata_oe), 32'd0);
        chk("R9 reset data",   32'(sdata_o),  32'd0);
        rst_n = 1'b1;
        step();
        check_idle("R9 after reset");

        // Corners: most negative, most positive, zero, minus one
        run_frame(12'h800, 1'b0, 0);
        run_frame(12'h7FF, 1'b0, 2);
        run_frame(12'h000, 1'b0, 0);
        run_frame(12'hFFF, 1'b0, 0);
        run_frame(12'hE00, 1'b1, 2);
        run_frame(12'h1FF, 1'b1, 0);
        run_frame(12'hC00, 1'b1, 0);

        // Sweeps in both modes
        for (int v = 0; v < 4096; v += 41) run_frame(12'(v), 1'b0, 0);
        for (int v = 0; v < 1024; v += 13) run_frame({2'(v), 10'(v)}, 1'b1, v % 2);

        // Aborts, incl. select rise and sclk fall in one cycle
        run_abort(5, 1'b0);
        run_abort(7, 1'b1);
        run_abort(15, 1'b1);
        run_abort(0, 1'b0);
        run_frame(12'hA5C, 1'b0, 1);
        run_frame(12'h35A, 1'b1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule